// File: doc/BRIEF.md
# Variable-Depth Luma Pixel Multiplexer

This block turns graphics bytes read from an external SRAM into a stream of luma pixel codes that line up with a host bus clock, Phi2. It runs from a synchronous system clock that has a fixed number of ticks per bus cycle. Phi2 is synchronised into that clock, and its edges are detected there. A falling edge starts a new bus cycle. A rising edge captures the byte on the first SRAM port at once, and the byte on the second port a quarter cycle later.

When a cycle boundary arrives, both captured bytes move into a display holding register. The bytes captured during cycle N are therefore shown during cycle N+1. Inside a cycle, the phase counter's top three bits act as a slot phase that addresses a multiplexer; no pixel-rate shift register is used. The mode decides how the cycle is split: into 8, 4 or 2 equal slots of 1, 2 or 4 bits each.

The output has two lanes. The low nibble carries the code taken from the first byte and the high nibble carries the code from the second byte. A one-clock strobe marks the start of every slot.

Top module: `luma_pixel_mux`

## Requirements
- R1: While reset is asserted, and until the first Phi2 cycle begins, pixel_o and strobe_o are zero.
- R2: Phi2 passes through a two-flop synchroniser. If Phi2 is first sampled low at clock edge m, the phase counter restarts at edge m+2, and the first slot of the new cycle appears on the outputs after edge m+3.
- R3: Mode 0 splits the 16-tick cycle into 8 slots of 2 ticks each. Slot k (0..7) outputs bit 7-k of its byte in bit 0 of each lane, and lane bits 3:1 are zero.
- R4: Mode 1 gives 4 slots of 4 ticks each. Slot k (0..3) outputs byte bits {7-2k, 6-2k} in lane bits 1:0, and lane bits 3:2 are zero.
- R5: Modes 2 and 3 give 2 slots of 8 ticks each. The first slot outputs byte bits 7:4 and the second outputs bits 3:0.
- R6: If Phi2 is first sampled high at edge m, the first-port byte present at edge m+2 is captured.
- R7: The second-port byte is captured at edge m+6, a quarter cycle (4 ticks) after the first capture.
- R8: Captured bytes reach the display register only at a cycle boundary. The output of a cycle comes from the bytes captured in the cycle before it, and captures made mid-cycle leave the current output unchanged.
- R9: When enable_i is low at a clock edge, the output registered on that edge has pixel_o zero and strobe_o low.
- R10: strobe_o goes high for one clock at the first tick of each slot of the active mode, and stays low on all other ticks.
- R11: Until the first Phi2 falling edge after reset has been detected, no strobe is issued and pixel_o stays zero.
- R12: pixel_o[3:0] carries the code from the first-port byte and pixel_o[7:4] carries the code from the second-port byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 16 ticks per bus cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | Host bus clock, asynchronous |
| sram_a_i | input | 8 | Byte from the first SRAM bank |
| sram_b_i | input | 8 | Byte from the second SRAM bank |
| mode_i | input | 2 | 0: 1-bit, 1: 2-bit, 2/3: 4-bit |
| enable_i | input | 1 | Output enable |
| pixel_o | output | 8 | {lane B code, lane A code} |
| strobe_o | output | 1 | Slot start pulse |

## Verification
Every result is due a fixed number of edges after the Phi2 sample that caused it. The output slot phase restarts three edges after Phi2 is first seen low. Byte captures take place two and six edges after Phi2 is first seen high. Enable and mode take effect on the output one edge after they are sampled. The bench keeps track of the edge index of every detected Phi2 transition and derives the capture, swap and slot timings from those indices. It samples the outputs at each falling clock edge, after the registering edge, so every comparison lands in the exact cycle in which that result is due.

// File: rtl/luma_pkg.sv
package luma_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned LANES  = 2;

  typedef enum logic [1:0] {
    MODE_1B     = 2'd0,
    MODE_2B     = 2'd1,
    MODE_4B     = 2'd2,
    MODE_4B_ALT = 2'd3
  } pix_mode_e;

  // ph: 3-bit slot phase within the bus cycle
  function automatic logic [CODE_W-1:0] pick_code(input logic [BYTE_W-1:0] b,
                                                  input logic [2:0] ph,
                                                  input pix_mode_e m);
    logic [CODE_W-1:0] c;
    logic [2:0] bi;
    c  = '0;
    bi = '0;
    unique case (m)
      MODE_1B: begin
        bi = 3'd7 - ph;
        c  = {3'b000, b[bi]};
      end
      MODE_2B: begin
        bi = 3'd6 - {ph[2:1], 1'b0};
        c  = {2'b00, b[bi+:2]};
      end
      default: c = ph[2] ? b[3:0] : b[7:4];
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lpm_phi2_sync.sv
module lpm_phi2_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned SW = SYNC_STAGES + 1;

  logic [SW-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SW-2:0], phi2_i};
  end

  // last stage is the edge-detect history flop
  assign rise_o = sync_q[SW-2] & ~sync_q[SW-1];
  assign fall_o = sync_q[SW-1] & ~sync_q[SW-2];
endmodule

// File: rtl/lpm_phase_gen.sv
module lpm_phase_gen #(
  parameter int unsigned TICKS = 16,
  localparam int unsigned CNT_W = $clog2(TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  output logic [CNT_W-1:0] tick_o,
  output logic             run_o
);
  logic [CNT_W-1:0] tick_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      run_q  <= 1'b0;
    end else if (fall_i) begin
      tick_q <= '0;
      run_q  <= 1'b1;
    end else if (run_q) begin
      tick_q <= tick_q + 1'b1;  // free-runs if Phi2 stalls
    end
  end

  assign tick_o = tick_q;
  assign run_o  = run_q;
endmodule

// File: rtl/lpm_byte_capture.sv
module lpm_byte_capture
  import luma_pkg::*;
#(
  parameter int unsigned TICKS = 16,
  localparam int unsigned QTR   = TICKS / 4,
  localparam int unsigned AGE_W = $clog2(QTR) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] sram_a_i,
  input  logic [BYTE_W-1:0] sram_b_i,
  output logic [BYTE_W-1:0] disp_a_o,
  output logic [BYTE_W-1:0] disp_b_o
);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(QTR - 1);

  logic [BYTE_W-1:0] cap_a_q, cap_b_q, disp_a_q, disp_b_q;
  logic [AGE_W-1:0]  age_q;
  logic              b_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a_q  <= '0;
      cap_b_q  <= '0;
      age_q    <= '0;
      b_pend_q <= 1'b0;
    end else if (rise_i) begin
      cap_a_q  <= sram_a_i;
      age_q    <= '0;
      b_pend_q <= 1'b1;
    end else if (b_pend_q) begin
      if (age_q == AGE_LAST) begin
        cap_b_q  <= sram_b_i;
        b_pend_q <= 1'b0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  // holding stage: previous cycle's bytes stay on show while new ones arrive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_a_q <= '0;
      disp_b_q <= '0;
    end else if (fall_i) begin
      disp_a_q <= cap_a_q;
      disp_b_q <= cap_b_q;
    end
  end

  assign disp_a_o = disp_a_q;
  assign disp_b_o = disp_b_q;

  p_disp_only_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> ($stable(disp_a_q) && $stable(disp_b_q)));
endmodule

// File: rtl/lpm_slot_mux.sv
module lpm_slot_mux
  import luma_pkg::*;
#(
  parameter int unsigned TICKS = 16,
  localparam int unsigned CNT_W = $clog2(TICKS),
  localparam int unsigned SUB   = TICKS / 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CNT_W-1:0]         tick_i,
  input  logic                     run_i,
  input  logic                     enable_i,
  input  logic [1:0]               mode_i,
  input  logic [BYTE_W-1:0]        disp_a_i,
  input  logic [BYTE_W-1:0]        disp_b_i,
  output logic [LANES*CODE_W-1:0]  pixel_o,
  output logic                     strobe_o
);
  localparam logic [CNT_W-1:0] MASK_1B = CNT_W'(SUB - 1);
  localparam logic [CNT_W-1:0] MASK_2B = CNT_W'(2 * SUB - 1);
  localparam logic [CNT_W-1:0] MASK_4B = CNT_W'(4 * SUB - 1);

  pix_mode_e               mode;
  logic [2:0]              phase;
  logic [CNT_W-1:0]        slot_mask;
  logic [BYTE_W-1:0]       disp [LANES];
  logic [LANES*CODE_W-1:0] pixel_d, pixel_q;
  logic                    slot_start, strobe_q;

  assign mode    = pix_mode_e'(mode_i);
  assign phase   = tick_i[CNT_W-1 -: 3];
  assign disp[0] = disp_a_i;
  assign disp[1] = disp_b_i;

  always_comb begin
    unique case (mode)
      MODE_1B: slot_mask = MASK_1B;
      MODE_2B: slot_mask = MASK_2B;
      default: slot_mask = MASK_4B;
    endcase
  end

  assign slot_start = (tick_i & slot_mask) == '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign pixel_d[g*CODE_W +: CODE_W] = pick_code(disp[g], phase, mode);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pixel_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      pixel_q  <= (enable_i && run_i) ? pixel_d : '0;
      strobe_q <= enable_i && run_i && slot_start;
    end
  end

  assign pixel_o  = pixel_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/luma_pixel_mux.sv
module luma_pixel_mux
  import luma_pkg::*;
#(
  parameter int unsigned TICKS_PER_CYCLE = 16,
  parameter int unsigned SYNC_STAGES     = 2,
  localparam int unsigned CNT_W = $clog2(TICKS_PER_CYCLE)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phi2_i,
  input  logic [7:0] sram_a_i,
  input  logic [7:0] sram_b_i,
  input  logic [1:0] mode_i,
  input  logic       enable_i,
  output logic [7:0] pixel_o,
  output logic       strobe_o
);
  logic             rise, fall, run;
  logic [CNT_W-1:0] tick;
  logic [7:0]       disp_a, disp_b;

  lpm_phi2_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .phi2_i(phi2_i),
    .rise_o(rise), .fall_o(fall)
  );

  lpm_phase_gen #(.TICKS(TICKS_PER_CYCLE)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall),
    .tick_o(tick), .run_o(run)
  );

  lpm_byte_capture #(.TICKS(TICKS_PER_CYCLE)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .sram_a_i(sram_a_i), .sram_b_i(sram_b_i),
    .disp_a_o(disp_a), .disp_b_o(disp_b)
  );

  lpm_slot_mux #(.TICKS(TICKS_PER_CYCLE)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(run),
    .enable_i(enable_i), .mode_i(mode_i),
    .disp_a_i(disp_a), .disp_b_i(disp_b),
    .pixel_o(pixel_o), .strobe_o(strobe_o)
  );

  p_idle_until_sync_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (!strobe_o && pixel_o == 8'h00));

  p_disable_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!strobe_o && pixel_o == 8'h00));

  p_cycle_start_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> ##1 (strobe_o || !$past(enable_i)));

  p_one_bit_lanes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> (pixel_o[3:1] == 3'b000 && pixel_o[7:5] == 3'b000));
endmodule

// File: tb/tb_luma_pixel_mux.sv
module tb_luma_pixel_mux;
  localparam int TICKS = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       phi2_i = 1'b0;
  logic [7:0] sram_a_i = 8'h00;
  logic [7:0] sram_b_i = 8'h00;
  logic [1:0] mode_i = 2'd0;
  logic       enable_i = 1'b1;
  logic [7:0] pixel_o;
  logic       strobe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  luma_pixel_mux dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .phi2_i(phi2_i),
    .sram_a_i(sram_a_i), .sram_b_i(sram_b_i),
    .mode_i(mode_i), .enable_i(enable_i),
    .pixel_o(pixel_o), .strobe_o(strobe_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural model state, indexed by clock-edge number
  int  m_fall = -100, m_rise = -100;
  bit  h_prev = 1'b0;
  bit  m_valid = 1'b0;
  int  m_tick = 0;
  int  cap_a = 0, cap_b = 0, disp_a = 0, disp_b = 0;

  function automatic int lane_code(input int byte_v, input int t, input int md);
    int bits, tps, k;
    bits = (md == 0) ? 1 : (md == 1) ? 2 : 4;
    tps  = 2 * bits;
    k    = t / tps;
    return (byte_v >> (8 - bits * (k + 1))) & ((1 << bits) - 1);
  endfunction

  initial begin
    int n, lo_len, hi_len, ph_cnt, tps, bits;
    int exp_s, exp_a, exp_b;
    string tag_s, tag_a, tag_b;
    lo_len = 8; hi_len = 8; ph_cnt = 0;

    repeat (3) @(negedge clk_i);
    chk("R1", "strobe in reset", int'(strobe_o), 0);
    chk("R1", "pixel in reset", int'(pixel_o), 0);
    rst_ni = 1'b1;

    for (n = 1; n <= 900; n++) begin
      @(negedge clk_i);
      // expectation from state after edge n-1 and inputs present at edge n
      if (!enable_i || !m_valid) begin
        exp_s = 0; exp_a = 0; exp_b = 0;
      end else begin
        bits  = (mode_i == 2'd0) ? 1 : (mode_i == 2'd1) ? 2 : 4;
        tps   = 2 * bits;
        exp_s = (m_tick % tps == 0) ? 1 : 0;
        exp_a = lane_code(disp_a, m_tick, int'(mode_i));
        exp_b = lane_code(disp_b, m_tick, int'(mode_i));
      end
      if (!enable_i) begin
        tag_s = "R9"; tag_a = "R9"; tag_b = "R9";
      end else if (!m_valid) begin
        tag_s = "R11"; tag_a = "R11"; tag_b = "R11";
      end else begin
        tag_s = (m_tick == 0) ? "R2" : "R10";
        tag_a = (mode_i == 2'd0) ? "R3 R6" : (mode_i == 2'd1) ? "R4 R6" : "R5 R6";
        if (m_tick == 0) tag_a = {tag_a, " R8"};
        tag_b = "R7 R12";
      end
      chk(tag_s, "strobe", int'(strobe_o), exp_s);
      chk(tag_a, "lane A", int'(pixel_o[3:0]), exp_a);
      chk(tag_b, "lane B", int'(pixel_o[7:4]), exp_b);

      // advance model to state after edge n
      if (h_prev && !phi2_i) m_fall = n;
      if (!h_prev && phi2_i) m_rise = n;
      h_prev = phi2_i;
      if (n == m_fall + 2) begin
        disp_a = cap_a; disp_b = cap_b;
        m_valid = 1'b1; m_tick = 0;
      end else if (m_valid) begin
        m_tick = (m_tick + 1) % TICKS;
      end
      if (n == m_rise + 2) cap_a = int'(sram_a_i);
      if (n == m_rise + 6) cap_b = int'(sram_b_i);

      // drive inputs for edge n+1
      sram_a_i = 8'($urandom);
      sram_b_i = 8'($urandom);
      mode_i   = (n < 230) ? 2'd0 : (n < 430) ? 2'd1 : (n < 650) ? 2'd2 : (n < 780) ? 2'd3 : 2'd0;
      enable_i = !((n >= 320 && n < 345) || (n >= 700 && n < 711));
      lo_len   = (n >= 480 && n < 520) ? 12 : 8;
      hi_len   = (n >= 800 && n < 840) ? 10 : 8;
      if (n >= 20) begin
        phi2_i = (ph_cnt >= lo_len);
        ph_cnt = (ph_cnt + 1 >= lo_len + hi_len) ? 0 : ph_cnt + 1;
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule